// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects a parameterised number of interrupt request lines and gives one interrupt request to a single processor. Software gives each source a 4-bit priority. The block forwards a request only when the best pending priority is strictly above the processor's current priority, so a lower-priority handler never holds back a higher-priority one.

Sources 0 to 7 have no hardware input. Software raises and drops them, which lets a high-priority handler hand its remaining work to a lower-priority handler. The processor takes an interrupt by reading an acknowledge register. That read returns the source number and raises the current priority to the priority of that source. The previous current priority goes onto a last-in first-out stack, and a write to the end-of-interrupt register restores it. Software can also write the current priority directly to raise a ceiling around shared data.

Register map, with word addresses and an address width of clog2(N_SRC)+1:
- 0: current priority, read and write, bits [3:0].
- 1: acknowledge, read only.
- 2: end of interrupt, write with any data.
- 3: software requests. Writing bits [7:0] sets requests and writing bits [15:8] clears them. A read returns the eight request bits.
- Any address with the top bit set: the priority of the source whose number is in the low bits, bits [3:0].

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, the current priority reads 0, every source priority reads 0 and the software request register reads 0.
- R2: A pending source whose priority is 0 never drives `irq` high and is never acknowledged.
- R3: `irq` is 1 exactly when some pending source has a priority strictly greater than the current priority. A source at equal priority does not interrupt.
- R4: A read of the acknowledge register returns the number of the pending source with the highest priority. When priorities tie, the lowest source number wins.
- R5: An acknowledge read that returns a valid vector pushes the old current priority and sets the current priority to the served source's priority. `irq` drops in the next cycle when no higher source is pending.
- R6: A write to end of interrupt pops the stack and restores the previous current priority. With the stack empty, the write changes nothing. The stack holds 16 entries.
- R7: A write to the current priority blocks every source at or below the written level. Sources above that level still interrupt.
- R8: Software sources 0 to 7 are set by bits [7:0] and cleared by bits [15:8] of a write to address 3. When both are written together, set wins. These sources are masked by priority like any other source.
- R9: The hardware request inputs at indices 0 to 7 have no effect.
- R10: An acknowledge read while `irq` is 0 returns the value N_SRC and leaves the current priority unchanged.
- R11: Preemption nests. While a handler runs at level p, a source above p raises `irq` again, and ending each handler walks back through the earlier levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N_SRC | Level-sensitive hardware requests. Bits 0 to 7 are unused. |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe. A read of address 1 is the acknowledge. |
| reg_addr | input | clog2(N_SRC)+1 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The test drives single sources first, then groups of sources at equal priority to check the lowest-number tie-break, then groups at different priorities to check that the highest priority wins. Each group is applied at several ceilings, which separates the strict-greater rule from a greater-or-equal rule.

A nested sequence of acknowledges and end-of-interrupt writes, including one write with the stack empty, checks the order in which the stack restores levels. Software requests are set and cleared with overlapping set and clear bits. They are also posted below the running level, which shows that they stay masked until the level falls.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC = 32,
  parameter int PW    = 4,
  parameter int N_SW  = 8,
  parameter int DW    = 32,
  localparam int AW     = $clog2(N_SRC) + 1,
  localparam int LEVELS = 1 << PW,
  localparam int SPW    = $clog2(LEVELS + 1),
  localparam int IW     = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  localparam logic [AW-1:0] A_CUR = AW'(0);
  localparam logic [AW-1:0] A_ACK = AW'(1);
  localparam logic [AW-1:0] A_EOI = AW'(2);
  localparam logic [AW-1:0] A_SW  = AW'(3);

  logic [PW-1:0]    prio_q [N_SRC];
  logic [PW-1:0]    stk_q  [LEVELS];
  logic [PW-1:0]    cur_q;
  logic [SPW-1:0]   sp_q;
  logic [N_SW-1:0]  sw_q;
  logic [N_SRC-1:0] pend;
  logic [PW-1:0]    win_prio;
  logic [IW-1:0]    win_idx;
  logic [SPW-1:0]   sp_dec;
  logic             sel_prio, prio_ok, ack_fire, eoi_fire;
  logic [AW-2:0]    pidx;

  assign pend     = {src_req[N_SRC-1:N_SW], sw_q};
  assign sel_prio = reg_addr[AW-1];
  assign pidx     = reg_addr[AW-2:0];
  assign prio_ok  = sel_prio && (int'(pidx) < N_SRC);
  assign irq      = win_prio > cur_q;
  assign ack_fire = reg_rd && !sel_prio && reg_addr == A_ACK && irq && sp_q != SPW'(LEVELS);
  assign eoi_fire = reg_wr && !sel_prio && reg_addr == A_EOI && sp_q != '0;
  assign sp_dec   = sp_q - 1'b1;

  always_comb begin
    win_prio = '0;
    win_idx  = IW'(N_SRC);
    for (int i = 0; i < N_SRC; i++)
      if (pend[i] && prio_q[i] > win_prio) begin
        win_prio = prio_q[i];
        win_idx  = IW'(i);
      end
  end

  always_comb begin
    reg_rdata = '0;
    if (prio_ok)                reg_rdata = DW'(prio_q[pidx]);
    else if (reg_addr == A_CUR) reg_rdata = DW'(cur_q);
    else if (reg_addr == A_ACK) reg_rdata = ack_fire ? DW'(win_idx) : DW'(N_SRC);
    else if (reg_addr == A_SW)  reg_rdata = DW'(sw_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      sp_q  <= '0;
      sw_q  <= '0;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
      for (int i = 0; i < LEVELS; i++) stk_q[i] <= '0;
    end else begin
      if (ack_fire) begin
        stk_q[sp_q[PW-1:0]] <= cur_q;
        sp_q  <= sp_q + 1'b1;
        cur_q <= win_prio;
      end else if (eoi_fire) begin
        sp_q  <= sp_dec;
        cur_q <= stk_q[sp_dec[PW-1:0]];
      end else if (reg_wr && !sel_prio && reg_addr == A_CUR) begin
        cur_q <= reg_wdata[PW-1:0];
      end
      if (reg_wr && !sel_prio && reg_addr == A_SW)
        sw_q <= (sw_q & ~reg_wdata[N_SW+7:8]) | reg_wdata[N_SW-1:0];
      if (reg_wr && prio_ok)
        prio_q[pidx] <= reg_wdata[PW-1:0];
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_SRC = 32,
  parameter int PW    = 4,
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int SPW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          irq,
  input logic [PW-1:0] cur,
  input logic [SPW-1:0] sp,
  input logic [PW-1:0] win_prio,
  input logic          ack_fire
);
  p_ack_sets_cur_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> cur == $past(win_prio));

  p_ack_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> sp == $past(sp) + SPW'(1));

  p_eoi_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(2) && !ack_fire && sp != '0) |=> sp == $past(sp) - SPW'(1));

  p_stack_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(1 << PW));

  p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(1) && !irq) |-> reg_rdata == DW'(N_SRC));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .N_SRC(N_SRC), .PW(PW), .AW(AW), .DW(DW), .SPW(SPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq),
  .cur(cur_q), .sp(sp_q), .win_prio(win_prio), .ack_fire(ack_fire)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int N  = 32;
  localparam int AW = $clog2(N) + 1;
  localparam int CUR = 0, ACK = 1, EOI = 2, SW = 3, PB = 32;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_req = '0;
  logic reg_wr = 0, reg_rd = 0, probe = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;
  int    rd_exp[$];
  string rd_tag[$];
  int    irq_exp[$];
  string irq_tag[$];

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (reg_rd && rd_exp.size() > 0) begin
      int e; string t;
      e = rd_exp.pop_front(); t = rd_tag.pop_front();
      checks++;
      if (reg_rdata !== 32'(e)) begin
        fails++;
        $display("FAIL %s: rdata got %0d expected %0d", t, reg_rdata, e);
      end
    end
    if (probe && irq_exp.size() > 0) begin
      int e; string t;
      e = irq_exp.pop_front(); t = irq_tag.pop_front();
      checks++;
      if (irq !== 1'(e)) begin
        fails++;
        $display("FAIL %s: irq got %0d expected %0d", t, irq, e);
      end
    end
  end

  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = 32'(d);
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input int a, input int e, input string t);
    rd_exp.push_back(e); rd_tag.push_back(t);
    reg_rd = 1; reg_addr = AW'(a);
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic chk_irq(input int e, input string t);
    irq_exp.push_back(e); irq_tag.push_back(t);
    probe = 1;
    @(posedge clk); #1 probe = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk_irq(0, "R1");
    rd(CUR, 0, "R1");
    rd(PB + 12, 0, "R1");
    rd(SW, 0, "R1");
    // R9 hardware input at a software index
    wr(PB + 3, 5); src_req[3] = 1;
    chk_irq(0, "R9");
    src_req[3] = 0;
    // R2 level 0
    src_req[10] = 1;
    chk_irq(0, "R2");
    rd(ACK, N, "R2");
    // R3 / R4 / R5 single source
    wr(PB + 10, 3);
    chk_irq(1, "R3");
    rd(ACK, 10, "R4");
    chk_irq(0, "R5");
    rd(CUR, 3, "R5");
    // R11 nesting, strict comparison
    src_req[20] = 1; wr(PB + 20, 3);
    chk_irq(0, "R3");
    wr(PB + 20, 7);
    chk_irq(1, "R11");
    rd(ACK, 20, "R11");
    rd(CUR, 7, "R11");
    wr(EOI, 0);
    rd(CUR, 3, "R6");
    wr(EOI, 0);
    rd(CUR, 0, "R6");
    wr(EOI, 0);
    rd(CUR, 0, "R6");
    rd(ACK, 20, "R4");
    wr(EOI, 0);
    src_req[10] = 0; src_req[20] = 0;
    // R4 tie on equal priority
    wr(PB + 15, 6); wr(PB + 12, 6);
    src_req[15] = 1; src_req[12] = 1;
    rd(ACK, 12, "R4");
    wr(EOI, 0);
    src_req[12] = 0;
    rd(ACK, 15, "R4");
    wr(EOI, 0);
    src_req[15] = 0;
    // R7 ceiling
    wr(CUR, 6); wr(PB + 25, 6); src_req[25] = 1;
    chk_irq(0, "R7");
    wr(PB + 25, 7);
    chk_irq(1, "R7");
    wr(CUR, 7);
    chk_irq(0, "R7");
    wr(CUR, 0); src_req[25] = 0;
    // R8 software requests
    wr(SW, 32'h05);
    rd(SW, 5, "R8");
    wr(SW, 32'h0202);
    rd(SW, 7, "R8");
    wr(SW, 32'h0100);
    rd(SW, 6, "R8");
    wr(PB + 2, 4); wr(PB + 1, 4);
    chk_irq(1, "R8");
    rd(ACK, 1, "R8");
    rd(CUR, 4, "R5");
    wr(SW, 32'h0600);
    chk_irq(0, "R8");
    wr(EOI, 0);
    // R10 spurious acknowledge
    rd(ACK, N, "R10");
    rd(CUR, 0, "R10");
    // R8 hand-down to a lower level
    wr(PB + 30, 9); src_req[30] = 1;
    rd(ACK, 30, "R4");
    wr(PB + 0, 2); wr(SW, 32'h01);
    chk_irq(0, "R8");
    src_req[30] = 0;
    wr(EOI, 0);
    chk_irq(1, "R8");
    rd(ACK, 0, "R8");
    wr(SW, 32'h0100);
    wr(EOI, 0);
    rd(CUR, 0, "R6");
    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule